// File: doc/BRIEF.md
# PIO Timing Parameter Calculator

This block turns a requested programmed-I/O transfer mode, a required cycle time in nanoseconds and the period of the bus clock into three clock counts for a drive timing generator: address setup, strobe active and recovery. Setup and active times for modes 0 to 5 come from a small internal table. Each time is divided by the clock period and rounded up. The block then applies the limits of the timing generator. Recovery that exceeds its limit is moved into the active count. The recovery count is corrected for the silicon revision.

A controller pulses `start` with the request on its inputs. The block accepts the request only while it is idle and latches all request inputs at that point. It works through four divisions on one shared sequential divider and then presents the result with a one-cycle `done` pulse. Two drives can share one timing register set on a channel. For that case the caller passes the partner drive's counts and sets `pair_merge`, and the block returns the slower value of each count. A clock period of zero cannot be divided. It yields the slowest timing and raises `period_err`.

Top module: `pio_timing_calc`

## Requirements
- R1: A `pio_mode` value of 6 or 7 gives exactly the same counts as mode 5. Table times in ns (setup/active): mode0 70/165, mode1 50/125, mode2 30/100, mode3 30/80, mode4 25/70, mode5 20/50.
- R2: Setup, active, recovery and whole-cycle counts are each the ceiling of their time divided by `clk_period_ns`. Recovery time is `cycle_ns` minus setup time minus active time, and is taken as 0 when that difference is negative.
- R3: The recovery count is the larger of its rounded value and (cycle count minus setup count minus active count, floored at 0), and is never below 2.
- R4: The active count is raised to at least 2. If recovery is above 17, the amount above 17 is added to active and recovery becomes 17. Active is then limited to 16.
- R5: When `chip_rev` is greater than 1, recovery is reduced by one. Recovery is then limited to 16 for every revision.
- R6: The setup count is limited to 5.
- R7: With `pair_merge` high, each output count is the maximum of the computed count and the matching `peer_*` input.
- R8: A `clk_period_ns` of 0 gives setup 4, active 16, recovery 16 with no merge, and sets `period_err` with `done`. `period_err` stays set until the next accepted request completes.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the `done` cycle, and `done` is low again in the following cycle. A `start` while busy has no effect. Outputs change only when `done` is raised.
- R10: After reset, `busy`, `done` and `period_err` are 0, and the counts are 4, 16 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when idle |
| pio_mode | input | 3 | Requested transfer mode |
| cycle_ns | input | TIME_W | Required cycle time in ns |
| clk_period_ns | input | PER_W | Bus clock period in ns |
| chip_rev | input | 2 | Silicon revision of the timing generator |
| pair_merge | input | 1 | Merge with partner drive counts |
| peer_setup | input | CNT_W | Partner setup count |
| peer_active | input | CNT_W | Partner active count |
| peer_recovery | input | CNT_W | Partner recovery count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| period_err | output | 1 | Last request had a zero clock period |
| setup_cnt | output | CNT_W | Address setup clocks |
| active_cnt | output | CNT_W | Strobe active clocks |
| recovery_cnt | output | CNT_W | Recovery clocks |

## Verification
The hardest case to reach is the recovery spill. The recovery count must land just above 17, so that the excess visibly lengthens active without active reaching its own limit. A short clock period (10 ns) paired with a long cycle in the fastest mode gives an excess of exactly one clock. A companion vector at mode 0 drives both the spill and the setup limit. A second hard case is a request issued while busy. The bench pulses `start` with different inputs halfway through a computation and checks that the result belongs to the first request.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  localparam int MAX_MODE   = 5;
  localparam int MIN_ACT    = 2;
  localparam int MAX_ACT    = 16;
  localparam int MIN_REC    = 2;
  localparam int SPILL_REC  = 17;
  localparam int MAX_REC    = 16;
  localparam int MAX_SETUP  = 5;
  localparam int SLOW_SETUP = 4;
  localparam int SLOW_ACT   = 16;
  localparam int SLOW_REC   = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } calc_state_e;

  // Address setup time per mode, ns
  function automatic logic [7:0] mode_setup_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 8'd70;
      3'd1:    return 8'd50;
      3'd2:    return 8'd30;
      3'd3:    return 8'd30;
      3'd4:    return 8'd25;
      default: return 8'd20;
    endcase
  endfunction

  // Strobe active time per mode, ns
  function automatic logic [7:0] mode_active_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 8'd165;
      3'd1:    return 8'd125;
      3'd2:    return 8'd100;
      3'd3:    return 8'd80;
      3'd4:    return 8'd70;
      default: return 8'd50;
    endcase
  endfunction

endpackage

// File: rtl/pio_ceil_div.sv
// Sequential restoring divider returning ceil(num/den), one quotient bit per clock.
module pio_ceil_div #(
  parameter int NUM_W = 11,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W:0]   quot
);
  localparam int EW = NUM_W + 1;
  localparam int CW = $clog2(EW + 1);
  localparam int PW = EW + DEN_W;

  logic [EW-1:0]    dvd_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] num_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, dvd_q[EW-1]};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      num_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        // biasing by den-1 turns the floor division into a ceiling
        dvd_q <= EW'(num) + EW'(den) - EW'(1);
        rem_q <= '0;
        den_q <= den;
        num_q <= num;
        cnt_q <= CW'(EW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        dvd_q <= {dvd_q[EW-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = dvd_q;

  // R2: the quotient is the smallest value whose product with den covers num
  p_ceil_exact_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> ((PW'(quot) * PW'(den_q)) >= PW'(num_q)) &&
             ((quot == '0) || ((PW'(quot) - PW'(1)) * PW'(den_q) < PW'(num_q))));

endmodule

// File: rtl/pio_count_shaper.sv
// Applies rounding-derived recovery, limits, spill and revision correction.
module pio_count_shaper
  import pio_calc_pkg::*;
#(
  parameter int QW    = 12,
  parameter int CNT_W = 5
) (
  input  logic [QW-1:0]    s_q,
  input  logic [QW-1:0]    a_q,
  input  logic [QW-1:0]    r_q,
  input  logic [QW-1:0]    c_q,
  input  logic             rev_hi,
  output logic [CNT_W-1:0] s_o,
  output logic [CNT_W-1:0] a_o,
  output logic [CNT_W-1:0] r_o
);
  localparam int XW = QW + 2;

  logic [XW-1:0] sum_sa, r_alt, r_x, a_x, s_x;

  always_comb begin
    sum_sa = XW'(s_q) + XW'(a_q);
    r_alt  = (XW'(c_q) > sum_sa) ? XW'(c_q) - sum_sa : '0;
    r_x    = (r_alt > XW'(r_q)) ? r_alt : XW'(r_q);
    if (r_x < XW'(MIN_REC)) r_x = XW'(MIN_REC);
    a_x = (XW'(a_q) < XW'(MIN_ACT)) ? XW'(MIN_ACT) : XW'(a_q);
    if (r_x > XW'(SPILL_REC)) begin
      a_x = a_x + (r_x - XW'(SPILL_REC));
      r_x = XW'(SPILL_REC);
    end
    if (a_x > XW'(MAX_ACT)) a_x = XW'(MAX_ACT);
    if (rev_hi) r_x = r_x - XW'(1);
    if (r_x > XW'(MAX_REC)) r_x = XW'(MAX_REC);
    s_x = (XW'(s_q) > XW'(MAX_SETUP)) ? XW'(MAX_SETUP) : XW'(s_q);
    s_o = s_x[CNT_W-1:0];
    a_o = a_x[CNT_W-1:0];
    r_o = r_x[CNT_W-1:0];
  end

endmodule

// File: rtl/pio_pair_merge.sv
// Per-count maximum against a partner drive sharing the timing registers.
module pio_pair_merge #(
  parameter int LANES = 3,
  parameter int CNT_W = 5
) (
  input  logic                        en,
  input  logic [LANES-1:0][CNT_W-1:0] own,
  input  logic [LANES-1:0][CNT_W-1:0] peer,
  output logic [LANES-1:0][CNT_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i] = (en && (peer[i] > own[i])) ? peer[i] : own[i];
  end
endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_calc_pkg::*;
#(
  parameter int TIME_W = 11,
  parameter int PER_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        pio_mode,
  input  logic [TIME_W-1:0] cycle_ns,
  input  logic [PER_W-1:0]  clk_period_ns,
  input  logic [1:0]        chip_rev,
  input  logic              pair_merge,
  input  logic [CNT_W-1:0]  peer_setup,
  input  logic [CNT_W-1:0]  peer_active,
  input  logic [CNT_W-1:0]  peer_recovery,
  output logic              busy,
  output logic              done,
  output logic              period_err,
  output logic [CNT_W-1:0]  setup_cnt,
  output logic [CNT_W-1:0]  active_cnt,
  output logic [CNT_W-1:0]  recovery_cnt
);
  localparam int QW    = TIME_W + 1;
  localparam int NOPS  = 4;
  localparam int LANES = 3;

  calc_state_e state_q;
  logic [1:0]        op_idx_q;
  logic [2:0]        mode_q;
  logic [TIME_W-1:0] tc_q;
  logic [PER_W-1:0]  per_q;
  logic              rev_hi_q, merge_q, err_pend_q;
  logic [LANES-1:0][CNT_W-1:0] peer_q;
  logic [QW-1:0]     quo_q [NOPS];

  // operand selection for the shared divider
  logic [TIME_W-1:0] ts_w, ta_w, tr_w, num_w;
  logic [TIME_W:0]   tsa_w;
  logic              dv_done;
  logic [QW-1:0]     dv_quot;

  assign ts_w  = TIME_W'(mode_setup_ns(mode_q));
  assign ta_w  = TIME_W'(mode_active_ns(mode_q));
  assign tsa_w = {1'b0, ts_w} + {1'b0, ta_w};
  assign tr_w  = ({1'b0, tc_q} > tsa_w) ? TIME_W'({1'b0, tc_q} - tsa_w) : '0;

  always_comb begin
    case (op_idx_q)
      2'd0:    num_w = ts_w;
      2'd1:    num_w = ta_w;
      2'd2:    num_w = tr_w;
      default: num_w = tc_q;
    endcase
  end

  pio_ceil_div #(.NUM_W(TIME_W), .DEN_W(PER_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .go   (state_q == ST_ISSUE),
    .num  (num_w),
    .den  (per_q),
    .done (dv_done),
    .quot (dv_quot)
  );

  logic [CNT_W-1:0] sh_s, sh_a, sh_r;

  pio_count_shaper #(.QW(QW), .CNT_W(CNT_W)) shape_i (
    .s_q    (quo_q[0]),
    .a_q    (quo_q[1]),
    .r_q    (quo_q[2]),
    .c_q    (quo_q[3]),
    .rev_hi (rev_hi_q),
    .s_o    (sh_s),
    .a_o    (sh_a),
    .r_o    (sh_r)
  );

  logic [LANES-1:0][CNT_W-1:0] own_w, mrg_w;
  assign own_w = {sh_r, sh_a, sh_s};

  pio_pair_merge #(.LANES(LANES), .CNT_W(CNT_W)) merge_i (
    .en     (merge_q),
    .own    (own_w),
    .peer   (peer_q),
    .merged (mrg_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      op_idx_q     <= '0;
      mode_q       <= '0;
      tc_q         <= '0;
      per_q        <= '0;
      rev_hi_q     <= 1'b0;
      merge_q      <= 1'b0;
      err_pend_q   <= 1'b0;
      peer_q       <= '0;
      for (int i = 0; i < NOPS; i++) quo_q[i] <= '0;
      done         <= 1'b0;
      period_err   <= 1'b0;
      setup_cnt    <= CNT_W'(SLOW_SETUP);
      active_cnt   <= CNT_W'(SLOW_ACT);
      recovery_cnt <= CNT_W'(SLOW_REC);
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q     <= (pio_mode > 3'(MAX_MODE)) ? 3'(MAX_MODE) : pio_mode;
            tc_q       <= cycle_ns;
            per_q      <= clk_period_ns;
            rev_hi_q   <= (chip_rev > 2'd1);
            merge_q    <= pair_merge;
            peer_q     <= {peer_recovery, peer_active, peer_setup};
            op_idx_q   <= '0;
            err_pend_q <= (clk_period_ns == '0);
            state_q    <= (clk_period_ns == '0) ? ST_FINISH : ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (dv_done) begin
            quo_q[op_idx_q] <= dv_quot;
            if (op_idx_q == 2'(NOPS - 1)) begin
              state_q <= ST_FINISH;
            end else begin
              op_idx_q <= op_idx_q + 2'd1;
              state_q  <= ST_ISSUE;
            end
          end
        end
        default: begin
          done       <= 1'b1;
          period_err <= err_pend_q;
          if (err_pend_q) begin
            setup_cnt    <= CNT_W'(SLOW_SETUP);
            active_cnt   <= CNT_W'(SLOW_ACT);
            recovery_cnt <= CNT_W'(SLOW_REC);
          end else begin
            setup_cnt    <= mrg_w[0];
            active_cnt   <= mrg_w[1];
            recovery_cnt <= mrg_w[2];
          end
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable({setup_cnt, active_cnt, recovery_cnt}));
  p_active_range_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !period_err && !merge_q) |->
      (active_cnt >= CNT_W'(MIN_ACT)) && (active_cnt <= CNT_W'(MAX_ACT)));
  p_rec_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !period_err && !merge_q) |-> (recovery_cnt <= CNT_W'(MAX_REC)));
  p_setup_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !period_err && !merge_q) |-> (setup_cnt <= CNT_W'(MAX_SETUP)));
  p_merge_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !period_err && merge_q) |->
      (setup_cnt >= peer_q[0]) && (active_cnt >= peer_q[1]) &&
      (recovery_cnt >= peer_q[2]));
  p_slow_on_err_r8: assert property (@(posedge clk) disable iff (rst)
    (done && period_err) |->
      (setup_cnt == CNT_W'(SLOW_SETUP)) && (active_cnt == CNT_W'(SLOW_ACT)) &&
      (recovery_cnt == CNT_W'(SLOW_REC)));

endmodule

// File: tb/pio_timing_calc_tb.sv
module pio_timing_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  pio_mode = '0;
  logic [10:0] cycle_ns = '0;
  logic [7:0]  clk_period_ns = '0;
  logic [1:0]  chip_rev = '0;
  logic        pair_merge = 1'b0;
  logic [4:0]  peer_setup = '0, peer_active = '0, peer_recovery = '0;
  logic        busy, done, period_err;
  logic [4:0]  setup_cnt, active_cnt, recovery_cnt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pio_timing_calc dut_i (
    .clk(clk), .rst(rst), .start(start), .pio_mode(pio_mode),
    .cycle_ns(cycle_ns), .clk_period_ns(clk_period_ns), .chip_rev(chip_rev),
    .pair_merge(pair_merge), .peer_setup(peer_setup), .peer_active(peer_active),
    .peer_recovery(peer_recovery), .busy(busy), .done(done),
    .period_err(period_err), .setup_cnt(setup_cnt), .active_cnt(active_cnt),
    .recovery_cnt(recovery_cnt)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [10:0] tc;
    logic [7:0]  per;
    logic [1:0]  rev;
    logic        mrg;
    logic [4:0]  ps, pa, pr;
    logic [4:0]  es, ea, er;
    logic        eerr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 11'd600, 8'd30, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd6,  5'd13, 1'b0}, // R2 rounding
    '{3'd0, 11'd600, 8'd30, 2'd2, 1'b0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd6,  5'd12, 1'b0}, // R5 decrement
    '{3'd4, 11'd120, 8'd30, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd1, 5'd3,  5'd2,  1'b0}, // R3 floor
    '{3'd5, 11'd100, 8'd60, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd1, 5'd2,  5'd2,  1'b0}, // R4 active min
    '{3'd5, 11'd250, 8'd10, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd2, 5'd6,  5'd16, 1'b0}, // R4 spill
    '{3'd7, 11'd250, 8'd10, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd2, 5'd6,  5'd16, 1'b0}, // R1 mode 7
    '{3'd6, 11'd250, 8'd10, 2'd2, 1'b0, 5'd0, 5'd0, 5'd0, 5'd2, 5'd6,  5'd16, 1'b0}, // R1 mode 6
    '{3'd0, 11'd100, 8'd30, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd6,  5'd2,  1'b0}, // R2 negative
    '{3'd0, 11'd600, 8'd10, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd16, 5'd16, 1'b0}, // R6 setup cap
    '{3'd0, 11'd600, 8'd30, 2'd1, 1'b1, 5'd4, 5'd8, 5'd3, 5'd4, 5'd8,  5'd13, 1'b0}, // R7 merge
    '{3'd4, 11'd120, 8'd30, 2'd1, 1'b1, 5'd1, 5'd2, 5'd5, 5'd1, 5'd3,  5'd5,  1'b0}, // R7 merge
    '{3'd2, 11'd240, 8'd12, 2'd0, 1'b0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd9,  5'd10, 1'b0}, // R2 rev0
    '{3'd3, 11'd180, 8'd25, 2'd3, 1'b0, 5'd0, 5'd0, 5'd0, 5'd2, 5'd4,  5'd2,  1'b0}, // R5 rev3
    '{3'd0, 11'd600, 8'd0,  2'd1, 1'b1, 5'd5, 5'd5, 5'd5, 5'd4, 5'd16, 5'd16, 1'b1}, // R8 zero period
    '{3'd0, 11'd600, 8'd30, 2'd1, 1'b0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd6,  5'd13, 1'b0}  // R8 error cleared
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_vec(input vec_t v);
    pio_mode = v.mode; cycle_ns = v.tc; clk_period_ns = v.per; chip_rev = v.rev;
    pair_merge = v.mrg; peer_setup = v.ps; peer_active = v.pa; peer_recovery = v.pr;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input string req, input vec_t v);
    check(req, "setup", setup_cnt, v.es);
    check(req, "active", active_cnt, v.ea);
    check(req, "recovery", recovery_cnt, v.er);
    check(req, "period_err", period_err, v.eerr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "busy", busy, 0);
    check("R10", "done", done, 0);
    check("R10", "period_err", period_err, 0);
    check("R10", "setup", setup_cnt, 4);
    check("R10", "active", active_cnt, 16);
    check("R10", "recovery", recovery_cnt, 16);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive_vec(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check_result($sformatf("vec%0d", i), VECS[i]);
      @(negedge clk);
    end

    // R9: start accepted, busy follows, start while busy ignored
    drive_vec(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "busy after start", busy, 1);
    repeat (5) @(negedge clk);
    drive_vec(VECS[8]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R9", "busy at done", busy, 0);
    check_result("R9 ignored start", VECS[0]);
    @(negedge clk);
    check("R9", "done one cycle", done, 0);
    repeat (6) @(negedge clk);
    check("R9", "hold setup", setup_cnt, 3);
    check("R9", "hold active", active_cnt, 6);
    check("R9", "hold recovery", recovery_cnt, 13);
    check("R9", "still idle", busy, 0);

    // R8: period error persists across idle, clears after next request
    drive_vec(VECS[13]);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    check("R8", "err held", period_err, 1);
    drive_vec(VECS[2]);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check_result("R8 after err", VECS[2]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule